// File: doc/BRIEF.md
# Linked-Descriptor Scatter DMA Engine

This engine moves 32-bit words between a memory and a peripheral FIFO. Software gives it a list of descriptors that are linked in memory. Each descriptor holds a byte count, a buffer address and the address of the descriptor that follows it. After a run is started, the engine reads the first descriptor from the head pointer. It then streams that descriptor's buffer in the selected direction and jumps to the branch address. It keeps doing this until it finishes a descriptor that carries the last flag. Each run ends with a 4-bit event code, a sticky status bit and an interrupt that can be masked.

Software drives the engine through five word registers, selected by a 3-bit index: global control, descriptor pointer, channel control, interrupt enable and interrupt status. Memory is reached through a request/response port. The request is valid/ready, at most one request is in flight, and every accepted request gets exactly one response that may carry an error flag. Peripheral data flows over two valid/ready streams, one inbound (rx) and one outbound (tx). On both streams a word moves only in a cycle where valid and ready are both high. The engine holds its valid and payload stable until the other side accepts them. The peripheral can also raise a level `periph_end` to stop a transfer before all the bytes are used up.

Top module: `chain_dma`

## Requirements
- R1: After reset, every register reads zero (index 0 global control, 1 descriptor pointer, 2 channel control, 3 interrupt enable, 4 interrupt status), `irq` is low and no memory request is issued.
- R2: A write to global control with bit 8 set is a soft reset. It clears the enable (bit 0), the whole channel control register and the status bit, and it aborts a run in progress so that no further memory request or tx beat is issued. Bit 8 reads as zero. A write with bit 8 clear stores bit 0, and that bit reads back.
- R3: Writing channel control bit 7 starts a run only while the enable is set. While a run is active, writes to channel control and to the descriptor pointer are ignored, and bit 7 reads 1.
- R4: A descriptor occupies four words at address A: flags at A, buffer address at A+4, branch address at A+8, and a reserved word at A+12 that is never read. In the flags word, bits 15:0 are the byte count (a multiple of 4), bit 30 is the format bit and bit 31 marks the last descriptor. The three useful words are read in ascending address order.
- R5: After a descriptor that is not marked last, the next descriptor is fetched from its branch address, whatever that address is.
- R6: With channel control bit 22 clear (memory to peripheral), each buffer word is read at ascending addresses and presented on tx in the same order.
- R7: With bit 22 set (peripheral to memory), each rx word is written to the buffer at ascending addresses, in arrival order.
- R8: When the last-flagged descriptor's count is used up, the run bit clears, channel control bits 3:0 read 15 (success) and status bit 0 sets.
- R9: A descriptor whose format bit is clear, or a descriptor word read that returns `mem_rerr`, ends the run with event code 3. No buffer access is made for that descriptor.
- R10: A buffer access that returns `mem_rerr` ends the run with event code 4.
- R11: If `periph_end` is high when the engine is ready for the next data word and bytes remain in the current descriptor, the run ends with event code 5. When no bytes remain, `periph_end` has no effect, so a zero-count last descriptor still ends with code 15.
- R12: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 are both set. Writing 1 to status bit 0 clears it.
- R13: An offered memory request keeps its address, direction and data until `mem_ready`. An offered tx word stays valid and unchanged until `tx_ready`. `rx_ready` is only high while the engine can take the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Register index for the write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_idx | input | 3 | Register index for the read |
| reg_rd_data | output | 32 | Read data, combinational from `reg_rd_idx` |
| irq | output | 1 | Interrupt request |
| mem_valid | output | 1 | Memory request offered |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Response for the accepted request |
| mem_rdata | input | 32 | Read data of the response |
| mem_rerr | input | 1 | Response reports an error |
| rx_valid | input | 1 | Peripheral offers a word |
| rx_ready | output | 1 | Engine takes the rx word |
| rx_data | input | 32 | Inbound peripheral word |
| tx_valid | output | 1 | Engine offers a word |
| tx_ready | input | 1 | Peripheral takes the tx word |
| tx_data | output | 32 | Outbound peripheral word |
| periph_end | input | 1 | Peripheral ends the transfer early |

## Verification
A register write takes effect at the next rising edge. A run therefore begins one edge after its start write, and the first descriptor request appears in the following cycle. A terminal response or condition is registered as a completion pulse on the next edge, and the registers take the event code one edge after that. Because of this, the bench polls the run bit instead of assuming a fixed latency, and then reads the event code and status. Memory requests and tx words are compared against a queue of expected items on the falling edge of the cycle in which their handshake completes. The memory ready and tx ready inputs are throttled in fixed patterns, so the hold-until-accepted rules are exercised on every run.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  typedef enum logic [3:0] {
    EVT_NONE     = 4'd0,
    EVT_UNDERRUN = 4'd1,
    EVT_OVERRUN  = 4'd2,
    EVT_DESC     = 4'd3,
    EVT_DATA     = 4'd4,
    EVT_EARLY    = 4'd5,
    EVT_OK       = 4'd15
  } evt_e;

  typedef enum logic [2:0] {
    W_IDLE, W_DREQ, W_DWAIT, W_GATE, W_XREQ, W_XWAIT, W_PUSH
  } wstate_e;

  localparam int IDX_GCTL  = 0;
  localparam int IDX_DPTR  = 1;
  localparam int IDX_CCTL  = 2;
  localparam int IDX_IEN   = 3;
  localparam int IDX_ISTAT = 4;

  localparam int B_EN   = 0;
  localparam int B_SRST = 8;
  localparam int B_RUN  = 7;
  localparam int B_DIR  = 22;
  localparam int B_FMT  = 30;
  localparam int B_LAST = 31;
endpackage

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_data,
  input  logic              done_i,
  input  evt_e              code_i,
  output logic              start_o,
  output logic              abort_o,
  output logic              dir_o,
  output logic [ADDR_W-1:0] head_o,
  output logic              irq_o
);
  logic en_q, ie_q, st_q, run_q, dir_q;
  logic [ADDR_W-1:0] head_q;
  evt_e evt_q;
  logic wr_gctl, wr_dptr, wr_cctl, wr_ien, wr_ist;

  assign wr_gctl = wr_en && (wr_idx == IDX_W'(IDX_GCTL));
  assign wr_dptr = wr_en && (wr_idx == IDX_W'(IDX_DPTR));
  assign wr_cctl = wr_en && (wr_idx == IDX_W'(IDX_CCTL));
  assign wr_ien  = wr_en && (wr_idx == IDX_W'(IDX_IEN));
  assign wr_ist  = wr_en && (wr_idx == IDX_W'(IDX_ISTAT));

  assign abort_o = wr_gctl && wr_data[B_SRST];
  assign start_o = wr_cctl && !run_q && en_q && wr_data[B_RUN];
  assign dir_o   = dir_q;
  assign head_o  = head_q;
  assign irq_o   = st_q & ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ie_q <= 1'b0; st_q <= 1'b0; run_q <= 1'b0; dir_q <= 1'b0;
      head_q <= '0; evt_q <= EVT_NONE;
    end else if (abort_o) begin
      en_q <= 1'b0; run_q <= 1'b0; dir_q <= 1'b0; st_q <= 1'b0; evt_q <= EVT_NONE;
    end else begin
      if (wr_gctl) en_q <= wr_data[B_EN];
      if (wr_dptr && !run_q) head_q <= wr_data[ADDR_W-1:0];
      if (wr_cctl && !run_q) begin
        dir_q <= wr_data[B_DIR];
        if (start_o) begin
          run_q <= 1'b1;
          evt_q <= EVT_NONE;
        end
      end
      if (wr_ien) ie_q <= wr_data[0];
      if (wr_ist && wr_data[0]) st_q <= 1'b0;
      if (done_i) begin
        run_q <= 1'b0;
        evt_q <= code_i;
        st_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      IDX_W'(IDX_GCTL):  rd_data[B_EN] = en_q;
      IDX_W'(IDX_DPTR):  rd_data[ADDR_W-1:0] = head_q;
      IDX_W'(IDX_CCTL): begin
        rd_data[3:0]   = evt_q;
        rd_data[B_RUN] = run_q;
        rd_data[B_DIR] = dir_q;
      end
      IDX_W'(IDX_IEN):   rd_data[0] = ie_q;
      IDX_W'(IDX_ISTAT): rd_data[0] = st_q;
      default:           rd_data = '0;
    endcase
  end

  // R8
  done_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !abort_o) |=> (!run_q && st_q));

  // R3
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(en_q));
endmodule

// File: rtl/chain_dma_walker.sv
module chain_dma_walker
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] head_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_rerr_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [31:0]       rx_data_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [31:0]       tx_data_o,
  input  logic              pend_i,
  output logic              done_o,
  output evt_e              code_o
);
  localparam logic [ADDR_W-1:0] ASTEP = ADDR_W'(4);
  localparam logic [CNT_W-1:0]  CSTEP = CNT_W'(4);

  wstate_e state_q;
  logic [ADDR_W-1:0] cur_q, buf_q, nxt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_q, done_q;
  logic [31:0]       word_q;
  logic [1:0]        didx_q;
  evt_e              code_q;
  logic              cnt_empty, fin, adv;
  evt_e              fin_code;

  assign cnt_empty   = (cnt_q[CNT_W-1:2] == '0);
  assign mem_valid_o = (state_q == W_DREQ) || (state_q == W_XREQ);
  assign mem_write_o = (state_q == W_XREQ) && dir_i;
  assign mem_addr_o  = (state_q == W_DREQ) ? cur_q + ADDR_W'({didx_q, 2'b00}) : buf_q;
  assign mem_wdata_o = word_q;
  assign rx_ready_o  = (state_q == W_GATE) && dir_i && !cnt_empty && !pend_i;
  assign tx_valid_o  = (state_q == W_PUSH);
  assign tx_data_o   = word_q;
  assign done_o      = done_q;
  assign code_o      = code_q;

  always_comb begin
    fin = 1'b0;
    fin_code = EVT_NONE;
    adv = 1'b0;
    case (state_q)
      W_DWAIT: if (mem_rvalid_i && (mem_rerr_i || (didx_q == 2'd0 && !mem_rdata_i[B_FMT]))) begin
        fin = 1'b1; fin_code = EVT_DESC;
      end
      W_GATE: if (cnt_empty && last_q) begin
        fin = 1'b1; fin_code = EVT_OK;
      end else if (!cnt_empty && pend_i) begin
        fin = 1'b1; fin_code = EVT_EARLY;
      end
      W_XWAIT: if (mem_rvalid_i) begin
        if (mem_rerr_i) begin
          fin = 1'b1; fin_code = EVT_DATA;
        end else adv = dir_i;
      end
      W_PUSH: adv = tx_ready_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE; cur_q <= '0; buf_q <= '0; nxt_q <= '0; cnt_q <= '0;
      last_q <= 1'b0; done_q <= 1'b0; word_q <= '0; didx_q <= '0; code_q <= EVT_NONE;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        state_q <= W_IDLE;
      end else if (fin) begin
        state_q <= W_IDLE;
        done_q  <= 1'b1;
        code_q  <= fin_code;
      end else begin
        if (adv) begin
          buf_q <= buf_q + ASTEP;
          cnt_q <= cnt_q - CSTEP;
        end
        case (state_q)
          W_IDLE: if (start_i) begin
            cur_q <= head_i; didx_q <= 2'd0; state_q <= W_DREQ;
          end
          W_DREQ: if (mem_ready_i) state_q <= W_DWAIT;
          W_DWAIT: if (mem_rvalid_i) begin
            case (didx_q)
              2'd0: begin
                cnt_q  <= mem_rdata_i[CNT_W-1:0];
                last_q <= mem_rdata_i[B_LAST];
              end
              2'd1:    buf_q <= mem_rdata_i[ADDR_W-1:0];
              default: nxt_q <= mem_rdata_i[ADDR_W-1:0];
            endcase
            if (didx_q == 2'd2) state_q <= W_GATE;
            else begin
              didx_q <= didx_q + 2'd1; state_q <= W_DREQ;
            end
          end
          W_GATE: if (cnt_empty) begin
            cur_q <= nxt_q; didx_q <= 2'd0; state_q <= W_DREQ;
          end else if (!dir_i) state_q <= W_XREQ;
          else if (rx_valid_i) begin
            word_q <= rx_data_i; state_q <= W_XREQ;
          end
          W_XREQ: if (mem_ready_i) state_q <= W_XWAIT;
          W_XWAIT: if (mem_rvalid_i) begin
            if (dir_i) state_q <= W_GATE;
            else begin
              word_q <= mem_rdata_i; state_q <= W_PUSH;
            end
          end
          W_PUSH: if (tx_ready_i) state_q <= W_GATE;
          default: state_q <= W_IDLE;
        endcase
      end
    end
  end

  // R13
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i && !abort_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i && !abort_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_write_o)));

  // R2
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!mem_valid_o && !tx_valid_o));
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_idx,
  input  logic [31:0]       reg_wr_data,
  input  logic [2:0]        reg_rd_idx,
  output logic [31:0]       reg_rd_data,
  output logic              irq,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rerr,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [31:0]       rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  input  logic              periph_end
);
  localparam int IDX_W = 3;

  logic start, abort, dir, done;
  logic [ADDR_W-1:0] head;
  evt_e code;

  chain_dma_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_idx(reg_wr_idx),
    .wr_data(reg_wr_data), .rd_idx(reg_rd_idx), .rd_data(reg_rd_data),
    .done_i(done), .code_i(code), .start_o(start), .abort_o(abort),
    .dir_o(dir), .head_o(head), .irq_o(irq)
  );

  chain_dma_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .abort_i(abort), .start_i(start), .dir_i(dir),
    .head_i(head), .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_write_o(mem_write), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .mem_rerr_i(mem_rerr),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .pend_i(periph_end), .done_o(done), .code_o(code)
  );
endmodule

// File: tb/test_chain_dma.sv
module test_chain_dma;
  localparam logic [31:0] FMT  = 32'h4000_0000;
  localparam logic [31:0] LAST = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_wr_idx = '0, reg_rd_idx = '0;
  logic [31:0] reg_wr_data = '0, reg_rd_data;
  logic irq, mem_valid, mem_write, mem_rvalid = 1'b0, mem_rerr = 1'b0;
  logic mem_ready = 1'b0, tx_ready = 1'b0, periph_end = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0, rx_data, tx_data;
  logic rx_valid, rx_ready, tx_valid;
  logic rx_en = 1'b0;

  logic [31:0] mem [0:511];
  logic [31:0] rx_src [0:63];
  logic [5:0]  rx_idx = '0, rx_n = '0;
  logic [64:0] exp_mem [$];
  logic [31:0] exp_tx [$];
  int checks = 0, errors = 0, cyc = 0, reqs = 0;
  string tag = "R1";
  logic hold_pend = 1'b0;
  logic [31:0] hold_d = '0;

  always #5 clk = ~clk;

  assign rx_valid = rx_en && (rx_idx != rx_n);
  assign rx_data  = rx_src[rx_idx];

  chain_dma i_chain_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
    .reg_wr_data(reg_wr_data), .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
    .irq(irq), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .periph_end(periph_end)
  );

  // memory model, throttling and rx source
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= (cyc % 3) != 2;
    tx_ready  <= (cyc % 4) != 1;
    mem_rvalid <= 1'b0;
    if (rst_n && mem_valid && mem_ready) begin
      mem_rvalid <= 1'b1;
      mem_rerr   <= mem_addr[12];
      mem_rdata  <= mem[mem_addr[10:2]];
      if (mem_write && !mem_addr[12]) mem[mem_addr[10:2]] <= mem_wdata;
    end
    if (rx_valid && rx_ready) rx_idx <= rx_idx + 6'd1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        checks++;
        if (!(tx_valid && tx_data == hold_d)) begin
          errors++;
          $display("FAIL R13 tx hold actual=%b/%h expected=1/%h", tx_valid, tx_data, hold_d);
        end
      end
      hold_pend = tx_valid && !tx_ready;
      hold_d = tx_data;
      if (mem_valid && mem_ready) begin
        logic [64:0] e;
        reqs++;
        checks++;
        if (exp_mem.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected request actual=%b/%h expected=none", tag, mem_write, mem_addr);
        end else begin
          e = exp_mem.pop_front();
          if (e[64] !== mem_write || e[63:32] !== mem_addr ||
              (mem_write && e[31:0] !== mem_wdata)) begin
            errors++;
            $display("FAIL %s request actual=%b/%h/%h expected=%b/%h/%h", tag,
                     mem_write, mem_addr, mem_wdata, e[64], e[63:32], e[31:0]);
          end
        end
      end
      if (tx_valid && tx_ready) begin
        logic [31:0] t;
        checks++;
        if (exp_tx.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected tx actual=%h expected=none", tag, tx_data);
        end else begin
          t = exp_tx.pop_front();
          if (t !== tx_data) begin
            errors++;
            $display("FAIL %s tx actual=%h expected=%h", tag, tx_data, t);
          end
        end
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic reg_wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_idx = idx[2:0]; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_rd_idx = idx[2:0];
    #1 d = reg_rd_data;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] f,
                          input logic [31:0] b, input logic [31:0] br);
    mem[a[10:2]] = f;
    mem[a[10:2] + 9'd1] = b;
    mem[a[10:2] + 9'd2] = br;
    mem[a[10:2] + 9'd3] = 32'hBAD0_BAD0;
  endtask

  // R4: flags, buffer and branch words, in that order; reserved word skipped
  task automatic q_desc(input logic [31:0] a);
    exp_mem.push_back({1'b0, a, 32'h0});
    exp_mem.push_back({1'b0, a + 32'd4, 32'h0});
    exp_mem.push_back({1'b0, a + 32'd8, 32'h0});
  endtask

  task automatic q_rd_tx(input logic [31:0] a);
    exp_mem.push_back({1'b0, a, 32'h0});
    exp_tx.push_back(mem[a[10:2]]);
  endtask

  task automatic q_wr(input logic [31:0] a, input logic [31:0] d);
    exp_mem.push_back({1'b1, a, d});
    rx_src[rx_n] = d;
    rx_n = rx_n + 6'd1;
  endtask

  task automatic run_wait();
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(2, d);
      if (!d[7]) return;
    end
    errors++;
    $display("FAIL %s run bit actual=1 expected=0", tag);
  endtask

  task automatic end_check(input logic [3:0] evt, input logic st);
    logic [31:0] d;
    reg_rd(2, d);
    chk({tag, " event"}, {24'h0, d[7], 3'h0, d[3:0]}, {24'h0, 1'b0, 3'h0, evt});
    reg_rd(4, d);
    chk({tag, " status"}, d, {31'h0, st});
    chk({tag, " pending mem"}, exp_mem.size(), 0);
    chk({tag, " pending tx"}, exp_tx.size(), 0);
  endtask

  initial begin
    logic [31:0] d;
    int r0;
    for (int i = 0; i < 512; i++) mem[i] = 32'hA500_0000 + i;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    tag = "R1";
    for (int i = 0; i < 5; i++) begin
      reg_rd(i, d);
      chk("R1 register", d, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 no request", reqs, 0);

    // R2 soft reset then enable read-back
    tag = "R2";
    reg_wr(0, 32'h100);
    reg_wr(0, 32'h1);
    reg_rd(0, d);
    chk("R2 enable read-back", d, 32'h1);

    // R4 R5 R6 R8 R12: memory to peripheral chain, branches jump around
    tag = "R4 R5 R6 R8";
    reg_wr(3, 32'h1);
    put_desc(32'h100, FMT | 32'd8, 32'h600, 32'h300);
    put_desc(32'h300, FMT | 32'd4, 32'h640, 32'h040);
    put_desc(32'h040, FMT | LAST | 32'd12, 32'h680, 32'h0);
    q_desc(32'h100); q_rd_tx(32'h600); q_rd_tx(32'h604);
    q_desc(32'h300); q_rd_tx(32'h640);
    q_desc(32'h040); q_rd_tx(32'h680); q_rd_tx(32'h684); q_rd_tx(32'h688);
    reg_wr(1, 32'h100);
    reg_wr(2, 32'h80);
    run_wait();
    end_check(4'd15, 1'b1);
    chk("R12 irq set", {31'h0, irq}, 32'h1);
    reg_wr(4, 32'h1);
    reg_rd(4, d);
    chk("R12 status cleared", d, 32'h0);
    chk("R12 irq cleared", {31'h0, irq}, 32'h0);

    // R7 peripheral to memory, interrupt masked (R12)
    tag = "R7";
    reg_wr(3, 32'h0);
    put_desc(32'h200, FMT | 32'd8, 32'h700, 32'h080);
    put_desc(32'h080, FMT | LAST | 32'd4, 32'h780, 32'h0);
    q_desc(32'h200); q_wr(32'h700, 32'hC0DE_0001); q_wr(32'h704, 32'hC0DE_0002);
    q_desc(32'h080); q_wr(32'h780, 32'hC0DE_0003);
    rx_en = 1'b1;
    reg_wr(1, 32'h200);
    reg_wr(2, 32'h0040_0080);
    run_wait();
    end_check(4'd15, 1'b1);
    chk("R12 irq masked", {31'h0, irq}, 32'h0);
    chk("R7 word0", mem[32'h700 >> 2], 32'hC0DE_0001);
    chk("R7 word2", mem[32'h780 >> 2], 32'hC0DE_0003);
    chk("R7 rx consumed", {26'h0, rx_idx}, {26'h0, rx_n});
    reg_wr(4, 32'h1);

    // R9 format bit clear on the second descriptor
    tag = "R9 format";
    put_desc(32'h100, FMT | 32'd4, 32'h600, 32'h300);
    put_desc(32'h300, 32'd4, 32'h640, 32'h0);
    q_desc(32'h100); q_rd_tx(32'h600);
    exp_mem.push_back({1'b0, 32'h300, 32'h0});
    reg_wr(1, 32'h100);
    reg_wr(2, 32'h80);
    run_wait();
    end_check(4'd3, 1'b1);
    reg_wr(4, 32'h1);

    // R9 descriptor read error
    tag = "R9 read error";
    exp_mem.push_back({1'b0, 32'h1000, 32'h0});
    reg_wr(1, 32'h1000);
    reg_wr(2, 32'h80);
    run_wait();
    end_check(4'd3, 1'b1);
    reg_wr(4, 32'h1);

    // R10 buffer read error
    tag = "R10";
    put_desc(32'h100, FMT | LAST | 32'd8, 32'h1200, 32'h0);
    q_desc(32'h100);
    exp_mem.push_back({1'b0, 32'h1200, 32'h0});
    reg_wr(1, 32'h100);
    reg_wr(2, 32'h80);
    run_wait();
    end_check(4'd4, 1'b1);
    reg_wr(4, 32'h1);

    // R11 early end with bytes left, then no effect on an empty last descriptor
    tag = "R11 early";
    periph_end = 1'b1;
    put_desc(32'h100, FMT | LAST | 32'd8, 32'h600, 32'h0);
    q_desc(32'h100);
    reg_wr(2, 32'h80);
    run_wait();
    end_check(4'd5, 1'b1);
    reg_wr(4, 32'h1);
    tag = "R11 empty";
    put_desc(32'h100, FMT | LAST, 32'h600, 32'h0);
    q_desc(32'h100);
    reg_wr(2, 32'h80);
    run_wait();
    end_check(4'd15, 1'b1);
    reg_wr(4, 32'h1);
    periph_end = 1'b0;

    // R3 run refused while disabled
    tag = "R3 disabled";
    reg_wr(0, 32'h100);
    reg_rd(0, d);
    chk("R2 enable cleared", d, 32'h0);
    r0 = reqs;
    reg_wr(2, 32'h80);
    repeat (10) @(negedge clk);
    reg_rd(2, d);
    chk("R3 run refused", {31'h0, d[7]}, 32'h0);
    chk("R3 no request", reqs, r0);

    // R3 writes ignored while running, R2 abort mid-run
    tag = "R2 abort";
    reg_wr(0, 32'h1);
    rx_en = 1'b0;
    put_desc(32'h100, FMT | LAST | 32'd8, 32'h700, 32'h0);
    q_desc(32'h100);
    reg_wr(2, 32'h0040_0080);
    repeat (30) @(negedge clk);
    reg_rd(2, d);
    chk("R3 running", {31'h0, d[7]}, 32'h1);
    reg_wr(1, 32'h300);
    reg_wr(2, 32'h0);
    reg_rd(1, d);
    chk("R3 pointer kept", d, 32'h100);
    reg_rd(2, d);
    chk("R3 control kept", d, 32'h0040_0080);
    reg_wr(0, 32'h100);
    reg_rd(2, d);
    chk("R2 control cleared", d, 32'h0);
    reg_rd(4, d);
    chk("R2 status cleared", d, 32'h0);
    r0 = reqs;
    rx_src[rx_n] = 32'hDEAD_0001;
    rx_n = rx_n + 6'd1;
    rx_en = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 no request after abort", reqs, r0);
    chk("R2 pending mem", exp_mem.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule